// File: doc/BRIEF.md
# Ternary CAM Array Controller

This block is a synthesizable behavioural model of a ternary content-addressable memory with 256 entries of 40 bits. Each entry holds two words: a storage word, which carries the value to compare, and a don't-care word, in which a 1 marks that column as a wildcard. The entries are grouped into 16 banks of 16 words. A single address selects an entry. A mode input picks which of the two words a read or write reaches, so filling a full entry takes two accesses over the one shared data path.

A search compares a 40-bit key against every entry in the same cycle and returns one hit bit per entry. A retention flag models a low-power state. While the flag is low, storage bits in a bank are lost wherever that bank's bottom entry has its wildcard bit set. With contiguous prefix-style wildcard patterns this loss never changes a search result. Reads taken while the flag is low are marked invalid.

Top module: `tcam_array_ctrl`

## Requirements
- R1: After reset, `rdata` is 0, `rd_invalid` is 0, `match` is all zeros, and every storage and don't-care bit is 0. A search for key 0 therefore hits all 256 entries.
- R2: Operation decode puts `cen` first, then `sen`, then `wen`. With `cen` low the block is in standby: no cell is written, and `rdata`, `rd_invalid` and `match` keep their values.
- R3: With `cen`=1 and `sen`=1 the cycle is a search whatever `wen` is. No entry is written and `rdata` is unchanged.
- R4: With `cen`=1, `sen`=0 and `wen`=1, `wdata` is written into the entry at `addr`. `mode`=0 writes the storage word and `mode`=1 writes the don't-care word. The other word of that entry is left unchanged.
- R5: With `cen`=1, `sen`=0 and `wen`=0, `rdata` shows the selected word of the addressed entry after the next rising edge (`mode`=0 storage, `mode`=1 don't-care). `rd_invalid` is 0 when `flag`=1.
- R6: A search registers `match` at the next rising edge. Bit e of `match` corresponds to address e. It is 1 exactly when, in every column whose don't-care bit is 0, the stored bit equals the `skey` bit.
- R7: `rdata` and `rd_invalid` change only after a read, and `match` changes only after a search.
- R8: At every rising edge with `flag`=0, in each bank, every storage bit in a column where the bank's bottom entry (word offset 15, address bank*16+15) has its don't-care bit set is forced to 0. Other columns, other banks and all don't-care bits are untouched. A storage write in the same cycle wins for its own entry.
- R9: A read performed while `flag`=0 sets `rd_invalid` to 1 together with that read's `rdata`.
- R10: While `flag`=1, storage contents are never altered except by writes.
- R11: When every entry of a bank has its don't-care bits set in the columns where the bottom entry's are set, a flag-low period leaves that bank's search results unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cen | input | 1 | Enable; low selects standby |
| sen | input | 1 | Search select when enabled |
| wen | input | 1 | Write (1) or read (0) when not searching |
| mode | input | 1 | 0 selects storage word, 1 selects don't-care word |
| flag | input | 1 | Retention flag; low permits data loss |
| addr | input | 8 | Entry address: [7:4] bank, [3:0] word |
| wdata | input | 40 | Write data |
| skey | input | 40 | Search key |
| rdata | output | 40 | Registered read data |
| rd_invalid | output | 1 | Registered marker: last read happened with flag low |
| match | output | 256 | Registered per-entry hit vector |

## Verification
The search is tried with four kinds of key. An exact key with a different wildcard byte separates masked columns from compared ones. An all-ones key hits only the one entry stored as ones. A zero key hits every untouched entry but not the written ones. A key differing in one compared bit must produce no hit. Prefix-pattern searches before and after a flag-low cycle show that loss stays confined to wildcard columns. Reads of the corrupted bank next to an untouched bank show that the loss follows the bottom entry's column mask, bank by bank.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_SRCH = 2'd1,
      OP_WR   = 2'd2,
      OP_RD   = 2'd3
   } tcam_op_e;
endpackage

// File: rtl/tcam_op_decode.sv
module tcam_op_decode
   import tcam_pkg::*;
(
   input  logic     en_i,
   input  logic     srch_i,
   input  logic     wr_i,
   output tcam_op_e op_o
);
   // enable outranks search, search outranks write select
   always_comb begin
      if (!en_i)       op_o = OP_IDLE;
      else if (srch_i) op_o = OP_SRCH;
      else if (wr_i)   op_o = OP_WR;
      else             op_o = OP_RD;
   end
endmodule

// File: rtl/tcam_bank.sv
module tcam_bank #(
   parameter int WIDTH      = 40,
   parameter int WORD_W     = 4,
   parameter bit DISTURB_EN = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_stor,
   input  logic                   wr_care,
   input  logic [WORD_W-1:0]      wsel,
   input  logic [WIDTH-1:0]       wdata,
   input  logic                   hold_lo,
   input  logic [WIDTH-1:0]       key,
   output logic [WIDTH-1:0]       rd_stor,
   output logic [WIDTH-1:0]       rd_care,
   output logic [(1<<WORD_W)-1:0] hit
);
   localparam int WORDS = 1 << WORD_W;

   logic [WIDTH-1:0] stor_q [WORDS];
   logic [WIDTH-1:0] care_q [WORDS];
   logic [WIDTH-1:0] kill;

   generate
      if (DISTURB_EN) begin : g_lossy
         assign kill = hold_lo ? care_q[WORDS-1] : '0;
      end else begin : g_ideal
         assign kill = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < WORDS; w++) begin
            stor_q[w] <= '0;
            care_q[w] <= '0;
         end
      end else begin
         for (int w = 0; w < WORDS; w++) begin
            if (wr_stor && (wsel == WORD_W'(w)))
               stor_q[w] <= wdata;
            else
               stor_q[w] <= stor_q[w] & ~kill;
            if (wr_care && (wsel == WORD_W'(w)))
               care_q[w] <= wdata;
         end
      end
   end

   assign rd_stor = stor_q[wsel];
   assign rd_care = care_q[wsel];

   generate
      for (genvar w = 0; w < WORDS; w++) begin : g_cmp
         assign hit[w] = ~|((stor_q[w] ^ key) & ~care_q[w]);
      end
   endgenerate

   // R10: with flag high and no storage write, storage stays put
   p_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_lo && !wr_stor) |=> (stor_q[0] == $past(stor_q[0])));

   // R8: wildcard words are never disturbed
   p_care_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_care |=> (care_q[WORDS-1] == $past(care_q[WORDS-1])));

   generate
      if (DISTURB_EN) begin : g_chk_loss
         // R8: after a flag-low edge, masked columns of the top word are zero
         p_wipe_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (hold_lo && !wr_stor) |=>
               ((stor_q[0] & $past(care_q[WORDS-1])) == '0));
      end
   endgenerate
endmodule

// File: rtl/tcam_array_ctrl.sv
module tcam_array_ctrl
   import tcam_pkg::*;
#(
   parameter int WIDTH      = 40,
   parameter int BANK_W     = 4,
   parameter int WORD_W     = 4,
   parameter bit DISTURB_EN = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cen,
   input  logic                        sen,
   input  logic                        wen,
   input  logic                        mode,
   input  logic                        flag,
   input  logic [BANK_W+WORD_W-1:0]    addr,
   input  logic [WIDTH-1:0]            wdata,
   input  logic [WIDTH-1:0]            skey,
   output logic [WIDTH-1:0]            rdata,
   output logic                        rd_invalid,
   output logic [(1<<(BANK_W+WORD_W))-1:0] match
);
   localparam int NBANKS  = 1 << BANK_W;
   localparam int WORDS   = 1 << WORD_W;
   localparam int ADDR_W  = BANK_W + WORD_W;
   localparam int ENTRIES = NBANKS * WORDS;

   generate
      if (WIDTH < 1 || BANK_W < 1 || WORD_W < 1) begin : g_bad_dims
         $error("tcam_array_ctrl: widths must be positive");
      end
      if (ENTRIES > 4096) begin : g_bad_size
         $error("tcam_array_ctrl: entry count too large");
      end
   endgenerate

   tcam_op_e op;

   tcam_op_decode u_dec (
      .en_i   (cen),
      .srch_i (sen),
      .wr_i   (wen),
      .op_o   (op)
   );

   logic [BANK_W-1:0] bank_sel;
   logic [WORD_W-1:0] word_sel;
   assign bank_sel = addr[ADDR_W-1:WORD_W];
   assign word_sel = addr[WORD_W-1:0];

   logic [WIDTH-1:0]   rd_stor_b [NBANKS];
   logic [WIDTH-1:0]   rd_care_b [NBANKS];
   logic [ENTRIES-1:0] hit_all;

   generate
      for (genvar b = 0; b < NBANKS; b++) begin : g_bank
         logic sel_b;
         assign sel_b = (op == OP_WR) && (bank_sel == BANK_W'(b));
         tcam_bank #(
            .WIDTH      (WIDTH),
            .WORD_W     (WORD_W),
            .DISTURB_EN (DISTURB_EN)
         ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_stor (sel_b && !mode),
            .wr_care (sel_b && mode),
            .wsel    (word_sel),
            .wdata   (wdata),
            .hold_lo (!flag),
            .key     (skey),
            .rd_stor (rd_stor_b[b]),
            .rd_care (rd_care_b[b]),
            .hit     (hit_all[b*WORDS +: WORDS])
         );
      end
   endgenerate

   logic [WIDTH-1:0] rd_word;
   assign rd_word = mode ? rd_care_b[bank_sel] : rd_stor_b[bank_sel];

   logic [WIDTH-1:0]   rdata_q;
   logic               rdinv_q;
   logic [ENTRIES-1:0] match_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
         rdinv_q <= 1'b0;
         match_q <= '0;
      end else begin
         if (op == OP_RD) begin
            rdata_q <= rd_word;
            rdinv_q <= !flag;
         end
         if (op == OP_SRCH)
            match_q <= hit_all;
      end
   end

   assign rdata      = rdata_q;
   assign rd_invalid = rdinv_q;
   assign match      = match_q;

   // R2: standby holds every output
   p_standby_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cen |=> ($stable(rdata) && $stable(match) && $stable(rd_invalid)));

   // R3: a search cycle leaves read data alone
   p_search_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cen && sen) |=> $stable(rdata));

   // R5: a read with flag high is reported valid
   p_read_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cen && !sen && !wen && flag) |=> !rd_invalid);

   // R7: hit vector moves only on a search
   p_match_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(cen && sen) |=> $stable(match));

   // R9: a read with flag low is reported invalid
   p_read_invalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cen && !sen && !wen && !flag) |=> rd_invalid);
endmodule

// File: tb/tb_tcam_array_ctrl.sv
module tb_tcam_array_ctrl;
   logic         clk = 1'b0;
   logic         rst_n;
   logic         cen, sen, wen, mode, flag;
   logic [7:0]   addr;
   logic [39:0]  wdata, skey;
   logic [39:0]  rdata;
   logic         rd_invalid;
   logic [255:0] match;

   always #10 clk = ~clk;

   tcam_array_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cen(cen), .sen(sen), .wen(wen),
      .mode(mode), .flag(flag), .addr(addr), .wdata(wdata), .skey(skey),
      .rdata(rdata), .rd_invalid(rd_invalid), .match(match)
   );

   int nchk = 0;
   int nfail = 0;

   // bench-side model of the cell contents and expected outputs
   logic [39:0]  ms [256];
   logic [39:0]  mc [256];
   logic [39:0]  exp_rd;
   logic         exp_inv;
   logic [255:0] exp_match;

   task automatic chk(input string tag, input logic [255:0] act,
                      input logic [255:0] expv);
      nchk++;
      if (act !== expv) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", tag, act, expv);
      end
   endtask

   function automatic logic [255:0] model_hits(input logic [39:0] k);
      logic [255:0] h;
      for (int e = 0; e < 256; e++)
         h[e] = (((ms[e] ^ k) & ~mc[e]) == 40'd0);
      return h;
   endfunction

   // one clock cycle: drive at negedge, update model at the edge, return at next negedge
   task automatic cyc(input logic c, input logic s, input logic w,
                      input logic m, input logic f, input logic [7:0] a,
                      input logic [39:0] d, input logic [39:0] k);
      logic [39:0] msk [16];
      logic        wr_s;
      cen = c; sen = s; wen = w; mode = m; flag = f;
      addr = a; wdata = d; skey = k;
      @(posedge clk);
      wr_s = 1'b0;
      if (c && s) exp_match = model_hits(k);
      else if (c && !s && !w) begin
         exp_rd  = m ? mc[a] : ms[a];
         exp_inv = !f;
      end
      for (int b = 0; b < 16; b++) msk[b] = f ? 40'd0 : mc[b*16+15];
      if (c && !s && w) begin
         if (m) mc[a] = d;
         else begin ms[a] = d; wr_s = 1'b1; end
      end
      for (int e = 0; e < 256; e++)
         if (!(wr_s && a == 8'(e))) ms[e] = ms[e] & ~msk[e/16];
      @(negedge clk);
   endtask

   task automatic idle(input logic f);
      cyc(1'b0, 1'b0, 1'b0, 1'b0, f, 8'd0, 40'd0, 40'd0);
   endtask
   task automatic wr(input logic [7:0] a, input logic m, input logic [39:0] d);
      cyc(1'b1, 1'b0, 1'b1, m, 1'b1, a, d, 40'd0);
   endtask
   task automatic rd(input logic [7:0] a, input logic m, input logic f);
      cyc(1'b1, 1'b0, 1'b0, m, f, a, 40'd0, 40'd0);
   endtask
   task automatic srch(input logic [39:0] k);
      cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'd0, 40'd0, k);
   endtask

   task automatic t_reset;
      chk("R1 rdata after reset", 256'(rdata), 256'd0);
      chk("R1 rd_invalid after reset", 256'(rd_invalid), 256'd0);
      chk("R1 match after reset", match, 256'd0);
      srch(40'd0);
      chk("R1 zero key hits all", match, {256{1'b1}});
      rd(8'd200, 1'b1, 1'b1);
      chk("R1 cleared care word", 256'(rdata), 256'd0);
   endtask

   task automatic t_write_read;
      wr(8'h00, 1'b0, 40'hA5_1234_5678);
      wr(8'h00, 1'b1, 40'h00_0000_00FF);
      wr(8'hFF, 1'b0, 40'hFF_FFFF_FFFF);
      rd(8'h00, 1'b0, 1'b1);
      chk("R4 storage word", 256'(rdata), 256'(exp_rd));
      chk("R5 valid read", 256'(rd_invalid), 256'd0);
      rd(8'h00, 1'b1, 1'b1);
      chk("R4 care word", 256'(rdata), 256'(40'h00_0000_00FF));
      rd(8'hFF, 1'b1, 1'b1);
      chk("R4 other half untouched", 256'(rdata), 256'd0);
      rd(8'hFF, 1'b0, 1'b1);
      chk("R5 read entry 255", 256'(rdata), 256'(40'hFF_FFFF_FFFF));
   endtask

   task automatic t_search;
      srch(40'hA5_1234_5600);
      chk("R6 wildcard byte key", match, exp_match);
      chk("R6 entry 0 hit", 256'(match[0]), 256'd1);
      srch(40'hFF_FFFF_FFFF);
      chk("R6 all-ones key", match, exp_match);
      srch(40'd0);
      chk("R6 zero key", match, exp_match);
      srch(40'hA5_1234_5778);
      chk("R6 one compared bit differs", 256'(match[0]), 256'd0);
   endtask

   task automatic t_priority;
      logic [39:0]  rd_before;
      logic [255:0] m_before;
      cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'd5, 40'hFF_FFFF_FFFF, 40'd0);
      chk("R3 search with wen high", match, exp_match);
      rd(8'd5, 1'b0, 1'b1);
      chk("R3 no write during search", 256'(rdata), 256'd0);
      rd_before = rdata;
      m_before  = match;
      cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'd6, 40'hFF_FFFF_FFFF, 40'd0);
      chk("R2 standby rdata hold", 256'(rdata), 256'(rd_before));
      chk("R2 standby match hold", match, m_before);
      rd(8'd6, 1'b0, 1'b1);
      chk("R2 no write in standby", 256'(rdata), 256'd0);
   endtask

   task automatic t_hold;
      logic [39:0]  rd_before;
      logic [255:0] m_before;
      rd(8'h00, 1'b0, 1'b1);
      rd_before = rdata;
      wr(8'd9, 1'b0, 40'h12_3456_789A);
      chk("R7 rdata held over write", 256'(rdata), 256'(rd_before));
      srch(40'h12_3456_789A);
      chk("R7 rdata held over search", 256'(rdata), 256'(rd_before));
      m_before = match;
      rd(8'd9, 1'b0, 1'b1);
      chk("R7 match held over read", match, m_before);
      chk("R7 new read data", 256'(rdata), 256'(40'h12_3456_789A));
   endtask

   task automatic t_disturb;
      wr(8'd32, 1'b0, 40'hFF_FFFF_FFFF);
      wr(8'd40, 1'b0, 40'hFF_FFFF_FFFF);
      wr(8'd47, 1'b1, 40'h00_0000_FFFF);
      wr(8'd80, 1'b0, 40'hFF_FFFF_FFFF);
      idle(1'b0);
      rd(8'd32, 1'b0, 1'b1);
      chk("R8 masked columns lost", 256'(rdata), 256'(40'hFF_FFFF_0000));
      chk("R8 model agrees", 256'(rdata), 256'(exp_rd));
      rd(8'd80, 1'b0, 1'b1);
      chk("R8 other bank untouched", 256'(rdata), 256'(40'hFF_FFFF_FFFF));
      rd(8'd47, 1'b1, 1'b1);
      chk("R8 care word kept", 256'(rdata), 256'(40'h00_0000_FFFF));
      rd(8'd40, 1'b0, 1'b0);
      chk("R9 invalid marker", 256'(rd_invalid), 256'd1);
      chk("R9 data with marker", 256'(rdata), 256'(40'hFF_FFFF_0000));
      rd(8'd40, 1'b0, 1'b1);
      chk("R5 marker clears", 256'(rd_invalid), 256'd0);
   endtask

   task automatic t_prefix;
      logic [255:0] m_before;
      for (int e = 112; e < 128; e++) begin
         wr(8'(e), 1'b1, 40'h00_0000_00FF);
         wr(8'(e), 1'b0, (40'(e) << 8) | 40'h5A);
      end
      srch(40'(115) << 8);
      m_before = match;
      chk("R11 prefix hit before", 256'(match[115]), 256'd1);
      idle(1'b0);
      idle(1'b0);
      srch(40'(115) << 8);
      chk("R11 search unchanged", match, m_before);
      rd(8'd115, 1'b0, 1'b1);
      chk("R8 wildcard byte cleared", 256'(rdata), 256'(40'(115) << 8));
   endtask

   task automatic t_flag_high;
      wr(8'd200, 1'b0, 40'h3C_5A69_C3A5);
      wr(8'd207, 1'b1, 40'hFF_FFFF_FFFF);
      for (int i = 0; i < 20; i++) idle(1'b1);
      rd(8'd200, 1'b0, 1'b1);
      chk("R10 storage intact", 256'(rdata), 256'(40'h3C_5A69_C3A5));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      for (int e = 0; e < 256; e++) begin
         ms[e] = '0;
         mc[e] = '0;
      end
      exp_rd = '0; exp_inv = 1'b0; exp_match = '0;
      rst_n = 1'b0;
      cen = 1'b0; sen = 1'b0; wen = 1'b0; mode = 1'b0; flag = 1'b1;
      addr = '0; wdata = '0; skey = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write_read();
      t_search();
      t_priority();
      t_hold();
      t_disturb();
      t_prefix();
      t_flag_high();
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule